// File: doc/BRIEF.md
# USB Device Interrupt Pin Controller

This block folds the interrupt activity of a USB device controller onto one pin for an external processor. One input side carries handshake strobes from the serial engine: each is tagged with its kind (ACK, NAK or NYET), an endpoint number and a direction. The other input side carries a vector of pending interrupt sources, a mask vector and a global enable. A one-byte configuration register sets three things:
- which handshake kinds count as events, chosen separately for the control endpoint, the IN endpoints and the OUT endpoints;
- whether the pin is driven as a level or as a fixed-width pulse;
- the active polarity of the pin.

The pin is driven by a four-state machine:
- `PS_IDLE`: the pin is inactive.
- `PS_LEVEL`: the level output is asserted.
- `PS_PULSE`: a pulse is being driven.
- `PS_REST`: a one-cycle inactive gap that separates back-to-back pulses.

The transitions are:
- idle→level: in level mode, when the global enable is set and an unmasked bit is pending.
- level→idle: when that condition clears, or when pulse mode is selected.
- idle→pulse: on a trigger in pulse mode.
- pulse→idle: at the end of the width, with nothing queued.
- pulse→rest: at the end of the width, when a trigger arrived during the pulse.
- rest→pulse: always, on the next cycle.

Every qualified handshake is also given out as a one-cycle strobe, so that a status register elsewhere can record it.

Top module: `irq_out_ctrl`

## Requirements
- R1: After reset the configuration byte reads 0xFC and the pin is inactive. With that value the pin is inactive high, because bit 0 is 0 (active-low).
- R2: When `cfg_we` is 1 and `bus_reset` is 0, `cfg_wdata` is loaded at the clock edge and read back on `cfg_rdata` in the next cycle. The layout is: bits 7:6 control-endpoint mode, bits 5:4 IN mode, bits 3:2 OUT mode, bit 1 pulse select, bit 0 active-high.
- R3: A `bus_reset` cycle sets bits 7:2 to ones and keeps bits 1:0. When it coincides with a write, it takes priority over the write.
- R4: Handshake kind codes are 00 ACK, 01 NAK, 10 NYET and 11 none. A mode value permits the following kinds: 00 permits ACK, NAK and NYET; 10 permits ACK and NYET; 01 and 11 permit ACK only. `hs_irq` is 1 in the cycle after a permitted strobe. Kind 11, and endpoint numbers of `NUM_EP` and above, never qualify.
- R5: Endpoint 0 is filtered by bits 7:6. Other endpoints are filtered by bits 5:4 when `hs_in`=1 and by bits 3:2 when `hs_in`=0.
- R6: In level mode (bit 1 = 0), the pin becomes active one cycle after `glint_en` is 1 and any bit of `pend & mask` is set. It becomes inactive one cycle after that condition clears.
- R7: Pending bits whose mask bit is 0 never drive the pin. While `glint_en` is 0, no pending bit drives the pin.
- R8: When bit 0 is 1, the active pin level is 1 and the idle level is 0. When bit 0 is 0, the levels are inverted.
- R9: In pulse mode (bit 1 = 1), a trigger makes the pin active for exactly `PULSE_CYC` cycles, starting in the next cycle.
- R10: A trigger is any of the following, each only while `glint_en` is 1: a qualified handshake; a newly set unmasked pending bit; `glint_en` rising while an unmasked bit is pending. Events that occur while `glint_en` is 0 are dropped.
- R11: A trigger during a pulse is queued. After the pulse the pin is idle for one cycle and then a fresh pulse starts. Several triggers during one pulse give a single follow-up pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| bus_reset | input | 1 | USB bus reset seen (one cycle per event) |
| cfg_rdata | output | 8 | Current configuration byte |
| hs_valid | input | 1 | Handshake strobe |
| hs_kind | input | 2 | Handshake kind: 00 ACK, 01 NAK, 10 NYET, 11 none |
| hs_ep | input | EP_W | Endpoint number of the handshake |
| hs_in | input | 1 | 1 = IN direction, 0 = OUT direction |
| pend | input | NUM_SRC | Pending interrupt sources |
| mask | input | NUM_SRC | Source enables, 1 = unmasked |
| glint_en | input | 1 | Global interrupt enable |
| hs_irq | output | 1 | Qualified handshake, one cycle after the strobe |
| irq_pin | output | 1 | Interrupt pin |

## Verification
The bench builds the block with `PULSE_CYC`=4, `NUM_SRC`=6, `EP_W`=4 and `NUM_EP`=8. A four-cycle pulse leaves room to place a trigger in the middle of a pulse and on its last cycle, which reaches both the queued follow-up pulse and the one-cycle gap before it. A 4-bit endpoint field with only eight endpoints lets random strobes hit the out-of-range endpoint numbers. Six sources make fully masked patterns common, so random stimulus often holds pending bits that must not reach the pin.

// File: rtl/irq_out_pkg.sv
package irq_out_pkg;

    typedef struct packed {
        logic [1:0] ctl_mode;
        logic [1:0] in_mode;
        logic [1:0] out_mode;
        logic       pulse_sel;
        logic       act_high;
    } irq_cfg_t;

    localparam logic [7:0] CFG_RST_VAL = 8'hFC;

    typedef enum logic [1:0] {
        HS_ACK  = 2'b00,
        HS_NAK  = 2'b01,
        HS_NYET = 2'b10,
        HS_NONE = 2'b11
    } hs_kind_e;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_LEVEL = 2'd1,
        PS_PULSE = 2'd2,
        PS_REST  = 2'd3
    } pin_state_e;

    function automatic logic mode_permits(input logic [1:0] mode, input hs_kind_e kind);
        logic ok;
        unique case (kind)
            HS_ACK:  ok = 1'b1;
            HS_NAK:  ok = (mode == 2'b00);
            HS_NYET: ok = (mode == 2'b00) || (mode == 2'b10);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
    import irq_out_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       bus_reset,
    output irq_cfg_t   cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= irq_cfg_t'(CFG_RST_VAL);
        end else if (bus_reset) begin
            cfg.ctl_mode <= 2'b11;
            cfg.in_mode  <= 2'b11;
            cfg.out_mode <= 2'b11;
        end else if (we) begin
            cfg <= irq_cfg_t'(wdata);
        end
    end

endmodule

// File: rtl/hs_event_filter.sv
module hs_event_filter
    import irq_out_pkg::*;
#(
    parameter int EP_W   = 4,
    parameter int NUM_EP = 8
) (
    input  irq_cfg_t            cfg,
    input  logic                hs_valid,
    input  hs_kind_e            hs_kind,
    input  logic [EP_W-1:0]     hs_ep,
    input  logic                hs_in,
    output logic                hit
);

    logic       ep_ok;
    logic [1:0] sel_mode;

    always_comb begin
        ep_ok = (32'(hs_ep) < NUM_EP);
        if (hs_ep == '0) begin
            sel_mode = cfg.ctl_mode;
        end else if (hs_in) begin
            sel_mode = cfg.in_mode;
        end else begin
            sel_mode = cfg.out_mode;
        end
        hit = hs_valid && ep_ok && mode_permits(sel_mode, hs_kind);
    end

endmodule

// File: rtl/irq_trig_detect.sv
module irq_trig_detect #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    input  logic               glint_en,
    input  logic               hs_hit,
    output logic               trig,
    output logic               lvl_req,
    output logic               hs_irq
);

    logic [NUM_SRC-1:0] unmasked;
    logic [NUM_SRC-1:0] prev_unmasked;
    logic               prev_en;
    logic               any_pend;
    logic               new_bit;
    logic               en_rise;

    always_comb begin
        unmasked = pend & mask;
        any_pend = |unmasked;
        new_bit  = |(unmasked & ~prev_unmasked);
        en_rise  = glint_en && !prev_en;
        lvl_req  = glint_en && any_pend;
        trig     = glint_en && (hs_hit || new_bit || (en_rise && any_pend));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_unmasked <= '0;
            prev_en       <= 1'b0;
            hs_irq        <= 1'b0;
        end else begin
            prev_unmasked <= unmasked;
            prev_en       <= glint_en;
            hs_irq        <= hs_hit;
        end
    end

endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
    import irq_out_pkg::*;
#(
    parameter int PULSE_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pulse_sel,
    input  logic       act_high,
    input  logic       trig,
    input  logic       lvl_req,
    output logic       irq_pin,
    output pin_state_e state
);

    localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

    pin_state_e    nxt;
    logic [CW-1:0] cnt;
    logic          queued;
    logic          active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= PS_IDLE;
            cnt    <= '0;
            queued <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= (state == PS_PULSE) ? cnt + 1'b1 : '0;
            if (state == PS_PULSE && trig) begin
                queued <= 1'b1;
            end else if (state == PS_REST) begin
                queued <= 1'b0;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PS_IDLE: begin
                if (!pulse_sel && lvl_req) begin
                    nxt = PS_LEVEL;
                end else if (pulse_sel && trig) begin
                    nxt = PS_PULSE;
                end
            end
            PS_LEVEL: begin
                if (pulse_sel || !lvl_req) begin
                    nxt = PS_IDLE;
                end
            end
            PS_PULSE: begin
                if (cnt == LAST) begin
                    nxt = (queued || trig) ? PS_REST : PS_IDLE;
                end
            end
            PS_REST: nxt = PS_PULSE;
            default: nxt = PS_IDLE;
        endcase
    end

    always_comb begin
        active  = (state == PS_LEVEL) || (state == PS_PULSE);
        irq_pin = act_high ? active : !active;
    end

endmodule

// File: rtl/irq_out_ctrl.sv
module irq_out_ctrl
    import irq_out_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int EP_W      = 4,
    parameter int NUM_EP    = 8,
    parameter int PULSE_CYC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_wdata,
    input  logic               bus_reset,
    output logic [7:0]         cfg_rdata,
    input  logic               hs_valid,
    input  logic [1:0]         hs_kind,
    input  logic [EP_W-1:0]    hs_ep,
    input  logic               hs_in,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    input  logic               glint_en,
    output logic               hs_irq,
    output logic               irq_pin
);

    irq_cfg_t   cfg;
    logic       hs_hit;
    logic       trig;
    logic       lvl_req;
    pin_state_e pin_st;

    assign cfg_rdata = cfg;

    irq_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .bus_reset (bus_reset),
        .cfg       (cfg)
    );

    hs_event_filter #(.EP_W(EP_W), .NUM_EP(NUM_EP)) u_filt (
        .cfg      (cfg),
        .hs_valid (hs_valid),
        .hs_kind  (hs_kind_e'(hs_kind)),
        .hs_ep    (hs_ep),
        .hs_in    (hs_in),
        .hit      (hs_hit)
    );

    irq_trig_detect #(.NUM_SRC(NUM_SRC)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend),
        .mask     (mask),
        .glint_en (glint_en),
        .hs_hit   (hs_hit),
        .trig     (trig),
        .lvl_req  (lvl_req),
        .hs_irq   (hs_irq)
    );

    irq_pin_fsm #(.PULSE_CYC(PULSE_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_sel (cfg.pulse_sel),
        .act_high  (cfg.act_high),
        .trig      (trig),
        .lvl_req   (lvl_req),
        .irq_pin   (irq_pin),
        .state     (pin_st)
    );

endmodule

// File: rtl/irq_out_chk.sv
module irq_out_chk
    import irq_out_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic       bus_reset,
    input logic [7:0] cfg_rdata,
    input logic       hs_valid,
    input logic       hs_irq,
    input logic       glint_en,
    input logic       irq_pin,
    input pin_state_e st
);

    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !bus_reset) |=> (cfg_rdata == $past(cfg_wdata)));

    assert_bus_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (cfg_rdata[7:2] == 6'h3F) && (cfg_rdata[1:0] == $past(cfg_rdata[1:0])));

    assert_hs_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hs_irq |-> $past(hs_valid));

    assert_level_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_LEVEL) |-> $past(glint_en));

    assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_IDLE || st == PS_REST) |-> (irq_pin != cfg_rdata[0]));

    assert_active_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_LEVEL || st == PS_PULSE) |-> (irq_pin == cfg_rdata[0]));

    assert_gap_then_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_REST) |=> (st == PS_PULSE));

endmodule

bind irq_out_ctrl irq_out_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .bus_reset (bus_reset),
    .cfg_rdata (cfg_rdata),
    .hs_valid  (hs_valid),
    .hs_irq    (hs_irq),
    .glint_en  (glint_en),
    .irq_pin   (irq_pin),
    .st        (pin_st)
);

// File: tb/tb_irq_out_ctrl.sv
`timescale 1ns/1ps
module tb_irq_out_ctrl;

    localparam int NS  = 6;
    localparam int EPW = 4;
    localparam int NEP = 8;
    localparam int PW  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [7:0]     cfg_wdata = '0;
    logic           bus_reset = 1'b0;
    logic [7:0]     cfg_rdata;
    logic           hs_valid = 1'b0;
    logic [1:0]     hs_kind = 2'b11;
    logic [EPW-1:0] hs_ep = '0;
    logic           hs_in = 1'b0;
    logic [NS-1:0]  pend = '0;
    logic [NS-1:0]  mask = '0;
    logic           glint_en = 1'b0;
    logic           hs_irq;
    logic           irq_pin;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_out_ctrl #(.NUM_SRC(NS), .EP_W(EPW), .NUM_EP(NEP), .PULSE_CYC(PW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bus_reset(bus_reset), .cfg_rdata(cfg_rdata), .hs_valid(hs_valid),
        .hs_kind(hs_kind), .hs_ep(hs_ep), .hs_in(hs_in), .pend(pend), .mask(mask),
        .glint_en(glint_en), .hs_irq(hs_irq), .irq_pin(irq_pin)
    );

    // reference state, stepped once per rising edge from the requirements
    bit [7:0]    m_cfg;
    int          m_st;     // 0 idle, 1 level, 2 pulse, 3 gap
    int          m_cnt;
    bit          m_q;
    bit [NS-1:0] m_prev;
    bit          m_pen;
    bit          m_hs;

    function automatic bit f_hit(bit [7:0] c, bit v, bit [1:0] k, bit [EPW-1:0] ep, bit dir_in);
        bit [1:0] m;
        if (!v || k == 2'b11 || int'(ep) >= NEP) return 1'b0;
        m = (ep == 0) ? c[7:6] : (dir_in ? c[5:4] : c[3:2]);
        case (k)
            2'b00:   return 1'b1;
            2'b01:   return m == 2'b00;
            2'b10:   return (m == 2'b00) || (m == 2'b10);
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit f_pin(bit [7:0] c, int s);
        bit act;
        act = (s == 1) || (s == 2);
        return c[0] ? act : !act;
    endfunction

    task automatic model_step();
        bit [NS-1:0] um;
        bit hit, trg, lvl;
        if (!rst_n) begin
            m_cfg = 8'hFC; m_st = 0; m_cnt = 0; m_q = 0; m_prev = '0; m_pen = 0; m_hs = 0;
            return;
        end
        um  = pend & mask;
        hit = f_hit(m_cfg, hs_valid, hs_kind, hs_ep, hs_in);
        lvl = glint_en && (|um);
        trg = glint_en && (hit || (|(um & ~m_prev)) || (!m_pen && (|um)));
        case (m_st)
            0: if (!m_cfg[1] && lvl) m_st = 1;
               else if (m_cfg[1] && trg) begin m_st = 2; m_cnt = 0; end
            1: if (m_cfg[1] || !lvl) m_st = 0;
            2: begin
                if (m_cnt == PW - 1) begin
                    m_st = (m_q || trg) ? 3 : 0;
                end else begin
                    if (trg) m_q = 1;
                    m_cnt++;
                end
            end
            default: begin m_st = 2; m_cnt = 0; m_q = 0; end
        endcase
        m_hs   = hit;
        m_prev = um;
        m_pen  = glint_en;
        if (bus_reset) m_cfg[7:2] = 6'h3F;
        else if (cfg_we) m_cfg = cfg_wdata;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R2/R3 cfg_rdata model", 32'(cfg_rdata), 32'(m_cfg));
        chk("R4/R5 hs_irq model", 32'(hs_irq), 32'(m_hs));
        chk("R6/R9/R11 irq_pin model", 32'(irq_pin), 32'(f_pin(m_cfg, m_st)));
    endtask

    task automatic wr_cfg(bit [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic hs_once(bit [1:0] k, bit [EPW-1:0] ep, bit dir_in, bit exp, string tag);
        hs_valid = 1'b1; hs_kind = k; hs_ep = ep; hs_in = dir_in;
        tick();
        hs_valid = 1'b0; hs_kind = 2'b11;
        chk(tag, 32'(hs_irq), 32'(exp));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst_n = 1'b1;
        chk("R1 cfg reset value", 32'(cfg_rdata), 32'hFC);
        chk("R1 pin idle high", 32'(irq_pin), 32'd1);

        // R2 / R3
        wr_cfg(8'h01);
        chk("R2 write readback", 32'(cfg_rdata), 32'h01);
        cfg_we = 1'b1; cfg_wdata = 8'h02; bus_reset = 1'b1;
        tick();
        cfg_we = 1'b0; bus_reset = 1'b0;
        chk("R3 bus reset wins, low bits kept", 32'(cfg_rdata), 32'hFD);

        // R4 / R5: ctl=00 in=01 out=10, level, active-low
        wr_cfg(8'h18);
        hs_once(2'b01, 4'd0, 1'b0, 1'b1, "R4 ep0 NAK mode00");
        hs_once(2'b10, 4'd0, 1'b1, 1'b1, "R4 ep0 NYET mode00");
        hs_once(2'b10, 4'd3, 1'b1, 1'b0, "R5 IN NYET mode01");
        hs_once(2'b00, 4'd3, 1'b1, 1'b1, "R5 IN ACK mode01");
        hs_once(2'b10, 4'd3, 1'b0, 1'b1, "R5 OUT NYET mode10");
        hs_once(2'b01, 4'd3, 1'b0, 1'b0, "R4 OUT NAK mode10");
        hs_once(2'b00, 4'd9, 1'b0, 1'b0, "R4 endpoint out of range");
        hs_once(2'b11, 4'd0, 1'b0, 1'b0, "R4 kind none");

        // R6 / R7 / R8: level mode, active-high
        wr_cfg(8'hFD);
        pend = 6'b000001; mask = '0; glint_en = 1'b1;
        tick(); tick();
        chk("R7 masked pending ignored", 32'(irq_pin), 32'd0);
        mask = '1; glint_en = 1'b0;
        tick(); tick();
        chk("R7 global enable clear", 32'(irq_pin), 32'd0);
        glint_en = 1'b1;
        tick();
        chk("R6 assert one cycle after enable", 32'(irq_pin), 32'd1);
        pend = '0;
        tick();
        chk("R6 release one cycle after clear", 32'(irq_pin), 32'd0);
        wr_cfg(8'hFC);
        chk("R8 active-low idle level", 32'(irq_pin), 32'd1);

        // R9 / R10 / R11: pulse mode, active-high
        glint_en = 1'b0;
        wr_cfg(8'hFF);
        pend = 6'b000010;
        tick(); tick();
        chk("R10 no pulse while disabled", 32'(irq_pin), 32'd0);
        glint_en = 1'b1;
        tick();
        chk("R10 enable rise with pending", 32'(irq_pin), 32'd1);
        repeat (5) tick();
        pend = '0;
        tick();
        pend = 6'b000001;
        tick();
        pend = 6'b000001;
        chk("R9 pulse start", 32'(irq_pin), 32'd1);
        hs_valid = 1'b1; hs_kind = 2'b00; hs_ep = '0;
        tick();
        hs_valid = 1'b0; hs_kind = 2'b11;
        tick(); tick();
        chk("R9 pulse still active", 32'(irq_pin), 32'd1);
        tick();
        chk("R11 gap before queued pulse", 32'(irq_pin), 32'd0);
        tick();
        chk("R11 queued pulse starts", 32'(irq_pin), 32'd1);
        repeat (3) tick();
        chk("R9 pulse last cycle", 32'(irq_pin), 32'd1);
        tick();
        chk("R9 pulse width end", 32'(irq_pin), 32'd0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(15) == 0) glint_en = ~glint_en;
            if ($urandom_range(3) == 0) pend[$urandom_range(NS-1)] ^= 1'b1;
            if ($urandom_range(31) == 0) mask = NS'($urandom);
            hs_valid = ($urandom_range(2) == 0);
            hs_kind  = 2'($urandom);
            hs_ep    = EPW'($urandom);
            hs_in    = 1'($urandom);
            cfg_we    = ($urandom_range(63) == 0);
            cfg_wdata = 8'($urandom);
            bus_reset = ($urandom_range(127) == 0);
            tick();
        end
        cfg_we = 1'b0; bus_reset = 1'b0; hs_valid = 1'b0;
        tick();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule